// File: doc/BRIEF.md
# Partitioned Distributed-Arithmetic FIR Filter

This block is a multiplierless finite impulse response filter. Each accepted input sample enters a delay line of `TAPS` words. The block then forms the dot product of that history with a fixed coefficient set. It does not multiply. It works one bit weight at a time, from the least significant bit up. For each weight, the same-weight bit of every stored sample makes up a lookup address. The coefficient set is split into groups of `GROUP` taps, and each group has its own small precomputed table. Each table holds, for every address, the sum of the group's coefficients whose address bit is set.

The group table outputs are added together. A shift-and-add accumulator then scales that sum to its bit weight. The sign-bit weight of the two's complement samples is subtracted instead of added. A full result therefore takes `SAMPLE_W` cycles whatever the tap count. Splitting the taps keeps the table storage at `(TAPS/GROUP)*2^GROUP` words instead of `2^TAPS`.

The coefficients come in through the `COEFS` parameter as a packed vector. A producer offers a sample with `inValid` while `busy` is low and reads the result when `outValid` pulses.

Top module: `daFirTop`

## Requirements
- R1: `outData` equals the exact sum over k of c[k]*x[k]. Both operands are two's complement. x[0] is the newest accepted sample, and coefficient k sits in bits [k*COEF_W +: COEF_W] of `COEFS`.
- R2: `outValid` is high for exactly one cycle. That cycle follows the `SAMPLE_W`-th rising edge after the edge at which the sample was accepted.
- R3: A sample is accepted only on an edge where `inValid` is high and `busy` is low. `busy` stays high from acceptance until the result is produced, and `outValid` is never high while `busy` is high. Samples offered while `busy` is high change neither the current result nor the delay line.
- R4: The delay line holds the last `TAPS` accepted samples. After reset every stored sample is zero.
- R5: During and right after reset, `busy` and `outValid` are low and `outData` is zero.
- R6: Histories made entirely of the most negative or the most positive sample give exact results. `outData` is `SAMPLE_W+COEF_W+log2(TAPS)` bits wide, and no intermediate sum overflows.
- R7: A sample of 1 followed by zeros produces the coefficients one by one in tap order. Each table word is the sum of the coefficients of its group whose address bit is 1.
- R8: `outData` holds its value in every cycle in which `outValid` is low.
- R9: Take coefficients 1, 2, 6, 4 on taps 0 to 3, zero on all other taps, and the samples 5, 15, 10, 0 fed in that order after reset. The result for the last sample is 130.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Offers `inSample` this cycle |
| inSample | input | SAMPLE_W | Two's complement input sample |
| busy | output | 1 | A result is being computed; offered samples are ignored |
| outValid | output | 1 | One-cycle strobe marking a new `outData` |
| outData | output | SAMPLE_W+COEF_W+$clog2(TAPS) | Two's complement filter result |

## Verification
The bench builds the block with 16 taps in four groups of four, 8-bit samples and 8-bit signed coefficients. The first four coefficients are 1, 2, 6, 4, so the small hand-worked case is checked against its own number. The other twelve include the extremes 127 and -128. Four groups of eight-bit samples let every group table see every address during a stream of full-scale negative and positive histories. These histories drive the sign-weight subtraction and the accumulator headroom to their limits. The eight-cycle result latency leaves room to offer unwanted samples during a computation and observe that they are ignored.

// File: rtl/daFirPkg.sv
package daFirPkg;

  // Per-cycle strobes from the sequencer to the arithmetic path.
  typedef struct packed {
    logic load;   // shift a new sample into the history and start a result
    logic step;   // process one bit weight
    logic first;  // lowest bit weight: accumulator starts from the table sum
    logic last;   // sign bit weight: table sum is subtracted, result latched
  } daStrobes_t;

endpackage

// File: rtl/daPartTable.sv
module daPartTable #(
  parameter int GROUP  = 4,
  parameter int COEF_W = 8,
  parameter int PART_W = COEF_W + 3,
  parameter logic [GROUP*COEF_W-1:0] GCOEFS = '0
) (
  input  logic [GROUP-1:0]          addr,
  output logic signed [PART_W-1:0]  word
);

  localparam int DEPTH = 2 ** GROUP;

  // Sum of the group coefficients selected by the set bits of the address.
  function automatic logic signed [PART_W-1:0] entryFor(input int a);
    logic signed [PART_W-1:0] total;
    logic [COEF_W-1:0] c;
    total = '0;
    for (int i = 0; i < GROUP; i++) begin
      if (a[i]) begin
        c = GCOEFS[i*COEF_W +: COEF_W];
        total = total + {{(PART_W-COEF_W){c[COEF_W-1]}}, c};
      end
    end
    return total;
  endfunction

  logic signed [PART_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : gEntry
    assign rom[a] = entryFor(a);
  end

  assign word = rom[addr];

endmodule

// File: rtl/daFirCtrl.sv
module daFirCtrl
  import daFirPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output daStrobes_t strobe,
  output logic       busy,
  output logic       outValid
);

  localparam int CNT_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strobe.load  = inValid && !busy;
    strobe.step  = busy;
    strobe.first = busy && (bitCnt == '0);
    strobe.last  = busy && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.last;
      if (strobe.load) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (strobe.last) begin
        busy   <= 1'b0;
        bitCnt <= '0;
      end else if (busy) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/daFirDatapath.sv
module daFirDatapath
  import daFirPkg::*;
#(
  parameter int TAPS     = 16,
  parameter int GROUP    = 4,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = SAMPLE_W + COEF_W + 4,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  daStrobes_t          strobe,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic [ACC_W-1:0]    outData
);

  localparam int NGROUP = TAPS / GROUP;
  localparam int LOGT   = $clog2(TAPS);
  localparam int PART_W = COEF_W + $clog2(GROUP) + 1;
  localparam int HW     = COEF_W + LOGT + 2;

  logic [SAMPLE_W-1:0]      history [TAPS];
  logic [SAMPLE_W-1:0]      bitShift [TAPS];
  logic signed [PART_W-1:0] partWord [NGROUP];
  logic signed [HW-1:0]     bitSum;
  logic signed [HW-1:0]     hiAcc;
  logic signed [HW-1:0]     baseVal;
  logic signed [HW-1:0]     mixSum;
  logic signed [HW-1:0]     hiNext;
  logic [SAMPLE_W-1:0]      loAcc;
  logic [SAMPLE_W-1:0]      loNext;

  // One small table per group, addressed by the current low bit of each tap.
  for (genvar g = 0; g < NGROUP; g++) begin : gPart
    logic [GROUP-1:0] addr;
    for (genvar i = 0; i < GROUP; i++) begin : gAddr
      assign addr[i] = bitShift[g*GROUP + i][0];
    end
    daPartTable #(
      .GROUP  (GROUP),
      .COEF_W (COEF_W),
      .PART_W (PART_W),
      .GCOEFS (COEFS[g*GROUP*COEF_W +: GROUP*COEF_W])
    ) u_tbl (
      .addr (addr),
      .word (partWord[g])
    );
  end

  // Sum of all partial tables for this bit weight.
  always_comb begin
    bitSum = '0;
    for (int g = 0; g < NGROUP; g++) begin
      bitSum = bitSum + {{(HW-PART_W){partWord[g][PART_W-1]}}, partWord[g]};
    end
  end

  // Shift-and-add: upper part shifts right, the retired bit enters loAcc.
  always_comb begin
    baseVal = strobe.first ? '0 : hiAcc;
    mixSum  = strobe.last ? (baseVal - bitSum) : (baseVal + bitSum);
    hiNext  = mixSum >>> 1;
    loNext  = {mixSum[0], loAcc[SAMPLE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) begin
        history[k]  <= '0;
        bitShift[k] <= '0;
      end
      hiAcc   <= '0;
      loAcc   <= '0;
      outData <= '0;
    end else if (strobe.load) begin
      history[0]  <= inSample;
      bitShift[0] <= inSample;
      for (int k = 1; k < TAPS; k++) begin
        history[k]  <= history[k-1];
        bitShift[k] <= history[k-1];
      end
    end else if (strobe.step) begin
      for (int k = 0; k < TAPS; k++) begin
        bitShift[k] <= bitShift[k] >> 1;
      end
      hiAcc <= hiNext;
      loAcc <= loNext;
      if (strobe.last) begin
        outData <= ACC_W'({hiNext, loNext});
      end
    end
  end

endmodule

// File: rtl/daFirTop.sv
module daFirTop
  import daFirPkg::*;
#(
  parameter int TAPS     = 16,
  parameter int GROUP    = 4,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS =
    128'h05_F0_12_07_FE_40_19_0C_0C_19_40_FE_07_12_F0_05
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     inValid,
  input  logic [SAMPLE_W-1:0]                      inSample,
  output logic                                     busy,
  output logic                                     outValid,
  output logic [SAMPLE_W+COEF_W+$clog2(TAPS)-1:0]  outData
);

  localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(TAPS);

  daStrobes_t strobe;

  daFirCtrl #(
    .SAMPLE_W (SAMPLE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .busy     (busy),
    .outValid (outValid)
  );

  daFirDatapath #(
    .TAPS     (TAPS),
    .GROUP    (GROUP),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W),
    .COEFS    (COEFS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSample (inSample),
    .outData  (outData)
  );

endmodule

// File: rtl/daFirChecker.sv
module daFirChecker #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             busy,
  input logic             outValid,
  input logic [ACC_W-1:0] outData
);

  // Counts the cycles busy has been high; compared against the result strobe.
  logic [31:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyRun <= '0;
    else if (busy)  busyRun <= busyRun + 1;
    else            busyRun <= '0;
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busyRun == 32'(SAMPLE_W)));

  assert_accept_only_offered_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inValid));

  assert_no_valid_while_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

endmodule

bind daFirTop daFirChecker #(
  .SAMPLE_W (SAMPLE_W),
  .ACC_W    (ACC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .busy     (busy),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/daFirTop_tb.sv
`timescale 1ns/1ps
module daFirTop_tb;

  localparam int TAPS  = 16;
  localparam int GROUP = 4;
  localparam int SW    = 8;
  localparam int CW    = 8;
  localparam int AW    = SW + CW + $clog2(TAPS);

  localparam int CO [TAPS] = '{1, 2, 6, 4, -3, 127, -128, 9,
                               0, -1, 55, -70, 33, 8, -17, 100};

  localparam int NVEC = 20;
  localparam int VEC [NVEC] = '{127, -128, -1, 0, 1, 64, -64, 99, -77, 127,
                                127, -128, -128, -1, -1, 37, -5, 120, -100, 2};

  function automatic logic [TAPS*CW-1:0] packCoefs();
    logic [TAPS*CW-1:0] v;
    for (int k = 0; k < TAPS; k++) v[k*CW +: CW] = CW'(CO[k]);
    return v;
  endfunction

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [SW-1:0] inSample = '0;
  logic          busy;
  logic          outValid;
  logic [AW-1:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  int hist [TAPS];

  always #4 clk = ~clk;

  daFirTop #(
    .TAPS (TAPS), .GROUP (GROUP), .SAMPLE_W (SW), .COEF_W (CW),
    .COEFS (packCoefs())
  ) u_dut (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inSample (inSample),
    .busy (busy), .outValid (outValid), .outData (outData)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint modelOut();
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(CO[k]) * longint'(hist[k]);
    return s;
  endfunction

  function automatic longint dutOut();
    return longint'($signed(outData));
  endfunction

  task automatic clearModel();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
  endtask

  // Offer one sample; optionally offer junk while busy. Returns the result.
  task automatic runSample(input int s, input bit junk, input string req,
                           output longint res);
    int cnt;
    @(negedge clk);
    inValid  = 1'b1;
    inSample = SW'(s);
    @(negedge clk);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    cnt = 0;
    while (!outValid && cnt < 4 * SW) begin
      check("R3 busy during computation", busy, 1);
      inValid  = junk && (cnt < SW - 1);
      inSample = SW'(s ^ 8'h5A);
      @(negedge clk);
      cnt++;
    end
    inValid = 1'b0;
    check("R2 result latency", cnt, SW);
    res = dutOut();
    check(req, res, modelOut());
    check("R3 busy low with result", busy, 0);
    @(negedge clk);
    check("R2 single-cycle strobe", outValid, 0);
    check("R8 result held", dutOut(), res);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 busy in reset", busy, 0);
    check("R5 outValid in reset", outValid, 0);
    check("R5 outData in reset", dutOut(), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 busy after reset", busy, 0);
    check("R5 outData after reset", dutOut(), 0);
    clearModel();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    longint r;
    clearModel();
    #1;
    check("R5 outValid at start", outValid, 0);
    doReset();

    // R9: hand-worked reference, newest sample 0.
    runSample(5, 1'b0, "R9 ref step", r);
    runSample(15, 1'b0, "R9 ref step", r);
    runSample(10, 1'b0, "R9 ref step", r);
    runSample(0, 1'b0, "R9 ref step", r);
    check("R9 reference result 130", r, 130);

    // R1 / R3: vector table, every third with junk offered while busy.
    for (int i = 0; i < NVEC; i++) begin
      runSample(VEC[i], (i % 3) == 0, "R1 dot product", r);
    end

    // R7: impulse response reproduces the coefficients in tap order.
    doReset();
    runSample(1, 1'b0, "R7 impulse", r);
    check("R7 impulse tap 0", r, CO[0]);
    for (int k = 1; k < TAPS; k++) begin
      runSample(0, 1'b0, "R7 impulse", r);
      check("R7 impulse coefficient", r, CO[k]);
    end

    // R6: full-scale negative then positive histories.
    for (int k = 0; k < TAPS; k++) runSample(-128, 1'b0, "R6 all most-negative", r);
    check("R6 full -128 history", r, modelOut());
    for (int k = 0; k < TAPS; k++) runSample(127, 1'b1, "R6 all most-positive", r);

    // R4: reset mid-stream clears the history.
    doReset();
    runSample(1, 1'b0, "R4 history cleared", r);
    check("R4 only newest tap remains", r, CO[0]);
    runSample(-1, 1'b0, "R4 two taps", r);
    check("R4 two taps", r, -CO[0] + CO[1]);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule